// File: doc/BRIEF.md
# Dual-Mode Line Latch and Drive Level Selector

This block is the output stage of a 160-channel LCD driver whose channels work either as segment drivers or as common (scan) drivers. A single 160-bit register serves both purposes. In segment mode, each falling edge of the line pulse copies the whole row buffer into the register at once. In common mode, each falling edge moves the register contents by one stage and loads a scan bit from one end pin. The direction input picks which end pin receives the bit and which end pin sends the far-end bit on to the next chip in a chain.

From each register bit, the mode, the frame-reversal signal and the display-off input, the block forms a 2-bit code for each channel. The code picks one of four drive levels. The analog level shifter further down the chain turns these codes into voltages.

The line pulse is sampled on the system clock. A falling edge is seen when the pulse is low at a clock edge after being high at the previous one. The register acts on that same clock edge.

Top module: `lcd_line_stage`

## Requirements
- R1: After reset the line register is all zero, so with display on, segment mode and frame high, every channel code is 2'b01 and both end-pin enables are low.
- R2: In segment mode (`seg_mode`=1), the register takes all of `row_data` at the clock edge where a line-pulse falling edge is detected. Bit i of `row_data` drives channel i.
- R3: If no line-pulse falling edge is detected (pulse held, rising edge, or only `row_data` or scan inputs changing), the register and the channel codes do not change.
- R4: In common mode with `scan_dir`=0, each falling edge moves bit i to bit i+1 and loads `end_a_in` into bit 0. Bit NCH-1 is driven on `end_b_out`.
- R5: In common mode with `scan_dir`=1, each falling edge moves bit i to bit i-1 and loads `end_b_in` into bit NCH-1. Bit 0 is driven on `end_a_out`.
- R6: `end_b_oe` is high only in common mode with `scan_dir`=0. `end_a_oe` is high only in common mode with `scan_dir`=1. Both are low in segment mode, and the two are never high together.
- R7: The level codes are 2'b00=V0, 2'b01=V12, 2'b10=V43 and 2'b11=VSS. In segment mode, a set bit gives V0 with frame high and VSS with frame low. A clear bit gives V12 with frame high and V43 with frame low.
- R8: In common mode, a set bit gives VSS with frame high and V0 with frame low. A clear bit gives V43 with frame high and V12 with frame low.
- R9: While `disp_on_n`... is low (display off), every channel code is 2'b11 (VSS) in either mode, whatever the data or frame. The register keeps its contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_pulse | input | 1 | Line pulse; its falling edge triggers load or shift |
| seg_mode | input | 1 | 1 = segment mode, 0 = common mode |
| frame_sig | input | 1 | Frame-reversal signal |
| disp_en_n | input | 1 | Display enable, active low blanking: low forces every output to VSS |
| scan_dir | input | 1 | Common-mode shift direction (0: toward high index) |
| row_data | input | NCH | Row buffer contents for segment load |
| end_a_in | input | 1 | Scan input at the channel-0 end pin |
| end_b_in | input | 1 | Scan input at the channel-(NCH-1) end pin |
| end_a_out | output | 1 | Value for the channel-0 end pin (register bit 0) |
| end_a_oe | output | 1 | Output enable for the channel-0 end pin |
| end_b_out | output | 1 | Value for the channel-(NCH-1) end pin (register bit NCH-1) |
| end_b_oe | output | 1 | Output enable for the channel-(NCH-1) end pin |
| lvl_code | output | 2*NCH | Drive level code; bits [2i+1:2i] belong to channel i |

## Verification
Segment loads use an alternating pattern and a sparse every-third-bit pattern. Together they show that each row bit reaches its own channel, with no swap or shift between neighbours. A second row change without a falling edge shows that a rising edge or row activity alone loads nothing. In common mode a single token is sent through all 160 stages in each direction. This shows the shift order, that the entry pin follows the direction, and the moment the token appears on the far end pin. Frame and display-off are toggled over loaded data to cover all four level codes in both modes.

// File: rtl/lcdls_pkg.sv
// Shared types for the line latch / level selector.
// Assumes nothing beyond the 2-bit level coding used on lvl_code.
package lcdls_pkg;
    typedef enum logic [1:0] {
        LVL_V0  = 2'b00,
        LVL_V12 = 2'b01,
        LVL_V43 = 2'b10,
        LVL_VSS = 2'b11
    } drv_lvl_e;
endpackage

// File: rtl/lcdls_edge_det.sv
// Detects a falling edge of the line pulse on the system clock.
// Assumes line_pulse is already synchronous to clk. The pulse flag is
// high in the cycle where the input is low after being high.
module lcdls_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_in,
    output logic fall
);
    logic prev_q;

    // Remember last sampled level of the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= pulse_in;
    end

    // Falling edge: high last cycle, low now.
    always_comb fall = prev_q & ~pulse_in;
endmodule

// File: rtl/lcdls_line_reg.sv
// Shared line register: parallel latch in segment mode, scan shift
// register in common mode. Acts only when step is high.
// Assumes NCH >= 2.
module lcdls_line_reg #(
    parameter int NCH = 160
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           step,
    input  logic           seg_mode,
    input  logic           dir_down,
    input  logic [NCH-1:0] row_data,
    input  logic           scan_in,
    output logic [NCH-1:0] q
);
    // Load, shift up, shift down or hold the line register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (step) begin
            if (seg_mode)      q <= row_data;
            else if (!dir_down) q <= {q[NCH-2:0], scan_in};
            else               q <= {scan_in, q[NCH-1:1]};
        end
    end
endmodule

// File: rtl/lcdls_level_cell.sv
// Picks one channel's 4-level drive code from its latched bit, the
// mode, frame and display enable. Purely combinational.
module lcdls_level_cell
    import lcdls_pkg::*;
(
    input  logic     bit_in,
    input  logic     seg_mode,
    input  logic     frame_sig,
    input  logic     blank_n,
    output drv_lvl_e code
);
    // Blanking wins; otherwise select by mode, data and frame.
    always_comb begin
        if (!blank_n) begin
            code = LVL_VSS;
        end else if (seg_mode) begin
            case ({bit_in, frame_sig})
                2'b11:   code = LVL_V0;
                2'b10:   code = LVL_VSS;
                2'b01:   code = LVL_V12;
                default: code = LVL_V43;
            endcase
        end else begin
            case ({bit_in, frame_sig})
                2'b11:   code = LVL_VSS;
                2'b10:   code = LVL_V0;
                2'b01:   code = LVL_V43;
                default: code = LVL_V12;
            endcase
        end
    end
endmodule

// File: rtl/lcd_line_stage.sv
// Top of the output stage: edge detect, shared line register,
// end-pin steering and one level cell per channel.
// Assumes all inputs are synchronous to clk; pad tri-state buffers
// sit outside and use the *_oe outputs.
module lcd_line_stage
    import lcdls_pkg::*;
#(
    parameter int NCH = 160
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_pulse,
    input  logic             seg_mode,
    input  logic             frame_sig,
    input  logic             disp_en_n,
    input  logic             scan_dir,
    input  logic [NCH-1:0]   row_data,
    input  logic             end_a_in,
    input  logic             end_b_in,
    output logic             end_a_out,
    output logic             end_a_oe,
    output logic             end_b_out,
    output logic             end_b_oe,
    output logic [2*NCH-1:0] lvl_code
);
    logic           lp_fall;
    logic           scan_in;
    logic [NCH-1:0] line_q;

    lcdls_edge_det u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pulse_in (line_pulse),
        .fall     (lp_fall)
    );

    // Entry pin follows the shift direction.
    always_comb scan_in = scan_dir ? end_b_in : end_a_in;

    lcdls_line_reg #(.NCH(NCH)) u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (lp_fall),
        .seg_mode (seg_mode),
        .dir_down (scan_dir),
        .row_data (row_data),
        .scan_in  (scan_in),
        .q        (line_q)
    );

    // Far-end bits and pin enables for chaining in common mode.
    always_comb begin
        end_a_out = line_q[0];
        end_b_out = line_q[NCH-1];
        end_a_oe  = ~seg_mode &  scan_dir;
        end_b_oe  = ~seg_mode & ~scan_dir;
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        drv_lvl_e code_i;
        lcdls_level_cell u_cell (
            .bit_in    (line_q[i]),
            .seg_mode  (seg_mode),
            .frame_sig (frame_sig),
            .blank_n   (disp_en_n),
            .code      (code_i)
        );
        assign lvl_code[2*i +: 2] = code_i;
    end
endmodule

// File: rtl/lcdls_chk.sv
// Assertion checker for lcd_line_stage, bound into every instance.
// Keeps its own copy of the line-pulse history.
module lcdls_chk #(
    parameter int NCH = 160
) (
    input logic             clk,
    input logic             rst_n,
    input logic             line_pulse,
    input logic             seg_mode,
    input logic             disp_en_n,
    input logic             scan_dir,
    input logic [NCH-1:0]   row_data,
    input logic             end_a_in,
    input logic             end_b_in,
    input logic             end_a_oe,
    input logic             end_b_oe,
    input logic [2*NCH-1:0] lvl_code,
    input logic [NCH-1:0]   line_q
);
    logic lp_prev;
    logic fall_c;

    // Independent pulse history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) lp_prev <= 1'b0;
        else        lp_prev <= line_pulse;
    end
    assign fall_c = lp_prev & ~line_pulse;

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> line_q == '0); // R1
    AST_SEG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_c && seg_mode) |=> line_q == $past(row_data)); // R2
    AST_HOLD_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_c |=> $stable(line_q)); // R3
    AST_SHIFT_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_c && !seg_mode && !scan_dir) |=>
            line_q == {$past(line_q[NCH-2:0]), $past(end_a_in)}); // R4
    AST_SHIFT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_c && !seg_mode && scan_dir) |=>
            line_q == {$past(end_b_in), $past(line_q[NCH-1:1])}); // R5
    AST_PIN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(end_a_oe && end_b_oe)); // R6
    AST_PIN_SEG_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        seg_mode |-> (!end_a_oe && !end_b_oe)); // R6
    AST_BLANK_VSS: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_en_n |-> lvl_code == {(2*NCH){1'b1}}); // R9
endmodule

bind lcd_line_stage lcdls_chk #(.NCH(NCH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_pulse (line_pulse),
    .seg_mode   (seg_mode),
    .disp_en_n  (disp_en_n),
    .scan_dir   (scan_dir),
    .row_data   (row_data),
    .end_a_in   (end_a_in),
    .end_b_in   (end_b_in),
    .end_a_oe   (end_a_oe),
    .end_b_oe   (end_b_oe),
    .lvl_code   (lvl_code),
    .line_q     (line_q)
);

// File: tb/lcd_line_stage_test.sv
`timescale 1ns/100ps
// Scoreboard bench: driver tasks push expected items, a monitor pops
// and compares them at the falling clock edge.
module lcd_line_stage_test;
    localparam int NCH = 160;

    typedef struct {
        logic [2*NCH-1:0] lvl;
        logic             a_oe;
        logic             b_oe;
        logic             a_out;
        logic             b_out;
        string            tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_pulse = 1'b0;
    logic seg_mode = 1'b1;
    logic frame_sig = 1'b1;
    logic disp_en_n = 1'b1;
    logic scan_dir = 1'b0;
    logic [NCH-1:0] row_data = '0;
    logic end_a_in = 1'b0;
    logic end_b_in = 1'b0;
    logic end_a_out, end_a_oe, end_b_out, end_b_oe;
    logic [2*NCH-1:0] lvl_code;

    logic [NCH-1:0] model = '0;
    exp_t sb_q[$];
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    lcd_line_stage #(.NCH(NCH)) uut (
        .clk(clk), .rst_n(rst_n), .line_pulse(line_pulse),
        .seg_mode(seg_mode), .frame_sig(frame_sig), .disp_en_n(disp_en_n),
        .scan_dir(scan_dir), .row_data(row_data),
        .end_a_in(end_a_in), .end_b_in(end_b_in),
        .end_a_out(end_a_out), .end_a_oe(end_a_oe),
        .end_b_out(end_b_out), .end_b_oe(end_b_oe),
        .lvl_code(lvl_code)
    );

    // Level code from the tables in R7, R8 and R9.
    function automatic logic [1:0] exp_code(logic b, logic seg, logic fr, logic en_n);
        if (!en_n) return 2'b11;
        if (seg) return b ? (fr ? 2'b00 : 2'b11) : (fr ? 2'b01 : 2'b10);
        return b ? (fr ? 2'b11 : 2'b00) : (fr ? 2'b10 : 2'b01);
    endfunction

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    // Push the expected outputs for the current model and inputs.
    task automatic expect_now(string tag);
        exp_t e;
        for (int i = 0; i < NCH; i++)
            e.lvl[2*i +: 2] = exp_code(model[i], seg_mode, frame_sig, disp_en_n);
        e.a_oe  = ~seg_mode & scan_dir;
        e.b_oe  = ~seg_mode & ~scan_dir;
        e.a_out = model[0];
        e.b_out = model[NCH-1];
        e.tag   = tag;
        sb_q.push_back(e);
    endtask

    // One line pulse (high then low); the model follows R2/R4/R5.
    task automatic line_step();
        line_pulse = 1'b1;
        cyc();
        line_pulse = 1'b0;
        cyc();
        if (seg_mode)       model = row_data;
        else if (!scan_dir) model = {model[NCH-2:0], end_a_in};
        else                model = {end_b_in, model[NCH-1:1]};
    endtask

    // Monitor: compare the oldest expected item at the falling edge.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (lvl_code !== e.lvl || end_a_oe !== e.a_oe || end_b_oe !== e.b_oe ||
                (e.a_oe && end_a_out !== e.a_out) || (e.b_oe && end_b_out !== e.b_out)) begin
                fails++;
                $display("FAIL %s: lvl=%h oe=%b%b out=%b%b expected lvl=%h oe=%b%b out=%b%b",
                         e.tag, lvl_code, end_a_oe, end_b_oe, end_a_out, end_b_out,
                         e.lvl, e.a_oe, e.b_oe, e.a_out, e.b_out);
            end
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        expect_now("R1 reset state");
        cyc();

        // R2/R7: alternating row load, both frame phases.
        for (int i = 0; i < NCH; i++) row_data[i] = i[0];
        line_step();
        expect_now("R2 alternating load frame high (R7)");
        cyc();
        frame_sig = 1'b0;
        expect_now("R7 segment codes frame low");
        cyc();

        // R3: row changes, pulse rises and stays high, no falling edge.
        row_data = ~row_data;
        cyc();
        line_pulse = 1'b1;
        cyc(); cyc();
        expect_now("R3 no falling edge keeps register");
        cyc();
        line_pulse = 1'b0;
        cyc();
        model = row_data;
        expect_now("R2 inverted load after delayed fall");
        cyc();

        // R2: sparse every-third pattern.
        for (int i = 0; i < NCH; i++) row_data[i] = (i % 3 == 0);
        frame_sig = 1'b1;
        line_step();
        expect_now("R2 sparse load");
        cyc();

        // R9: blanking in segment mode, then register kept.
        disp_en_n = 1'b0;
        expect_now("R9 blank in segment mode");
        cyc();
        disp_en_n = 1'b1;
        expect_now("R9 register kept after blank");
        cyc();

        // Common mode, direction up: token from end A.
        seg_mode = 1'b0;
        scan_dir = 1'b0;
        row_data = '1;
        expect_now("R6 R8 common mode up enables");
        cyc();
        end_a_in = 1'b1;
        line_step();
        end_a_in = 1'b0;
        expect_now("R4 token entered at bit 0");
        cyc();
        for (int k = 0; k < NCH + 2; k++) begin
            end_b_in = k[0];
            line_step();
            expect_now("R4 shift up");
            cyc();
        end
        frame_sig = 1'b0;
        expect_now("R8 common codes frame low");
        cyc();
        disp_en_n = 1'b0;
        expect_now("R9 blank in common mode");
        cyc();
        disp_en_n = 1'b1;

        // Common mode, direction down: token from end B.
        scan_dir = 1'b1;
        frame_sig = 1'b1;
        expect_now("R6 common mode down enables");
        cyc();
        end_b_in = 1'b1;
        line_step();
        end_b_in = 1'b0;
        expect_now("R5 token entered at top bit");
        cyc();
        for (int k = 0; k < NCH + 2; k++) begin
            end_a_in = k[0];
            line_step();
            expect_now("R5 shift down");
            cyc();
        end

        // Back to segment mode: pins released, load works again.
        seg_mode = 1'b1;
        for (int i = 0; i < NCH; i++) row_data[i] = (i < 8);
        line_step();
        expect_now("R6 R2 segment reload releases pins");
        cyc();
        cyc();
        done = 1'b1;
        finish_run();
    end
endmodule